// File: doc/BRIEF.md
# CPU Bus Wait-State Controller

This block decides, once per CPU clock, whether the current CPU bus access may finish or must be held in a wait state. Two parts of the address space can hold an access. The low shared-RAM window is shared with the display fetch logic. The CPU may use it only while the display is blanking, or while the current interleave slot belongs to the CPU. The high slow-peripheral window must be lined up with the low phase of a slow bus clock. The block makes that clock itself by dividing the CPU clock.

Each cycle the CPU side presents an address and an access strobe. The block answers with a registered ready flag one clock later. Reads and writes take the same decision, so the block has no direction input. Any other address completes at once. The divided clock is brought out so that peripherals and checkers can see it.

Top module: `wsc_top`

## Requirements
- R1: Reset is synchronous and active low. While reset is held and on the first cycle after it, `bus_ready` and `eclk_out` are 0, and no synchronization is in progress.
- R2: An access with `bus_addr` from 0x000000 to 0x3FFFFF, where `vid_blank` is 0 and `cpu_slot` is 0, gives `bus_ready` = 0 on the next cycle.
- R3: An access in the shared-RAM window, where `vid_blank` is 1 or `cpu_slot` is 1, gives `bus_ready` = 1 on the next cycle.
- R4: An access with `bus_addr` from 0x400000 to 0xDFFFFF gives `bus_ready` = 1 on the next cycle, whatever the values of `vid_blank` and `cpu_slot`.
- R5: The first strobed cycle of an access at or above 0xE00000 starts synchronization and gives `bus_ready` = 0 on the next cycle, even if `eclk_out` is already low.
- R6: Once synchronization is in progress, each strobed high-window cycle with `eclk_out` = 1 stalls. The first such cycle with `eclk_out` = 0 gives `bus_ready` = 1 and ends the synchronization. A further strobed cycle after that starts a new synchronization.
- R7: A cycle with `bus_strobe` = 0 gives `bus_ready` = 0 on the next cycle. It also cancels any synchronization in progress, and so does a strobed access outside the high window.
- R8: `eclk_out` repeats every 10 CPU clocks: 6 cycles low, then 4 cycles high. The first clock after reset is the first low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 24 | Byte address of the current access |
| bus_strobe | input | 1 | Access in progress this cycle |
| vid_blank | input | 1 | Display is in its blanking period |
| cpu_slot | input | 1 | Current interleave slot belongs to the CPU |
| eclk_out | output | 1 | Divided slow-peripheral clock |
| bus_ready | output | 1 | Registered ready: 1 lets the access finish, 0 holds it |

## Verification
Every decision is taken at a rising edge from the inputs present just before it. The result appears on `bus_ready` one clock later, so the bench drives inputs on falling edges and compares each decision at the next falling edge. `eclk_out` is checked on every such falling edge against a phase that the bench counts from the release of reset. The bench keeps its own synchronization flag, so a high-window release is expected exactly on the first low sample after the first stalled cycle.

// File: rtl/wsc_pkg.sv
// Package: shared types for the wait-state controller.
// Assumes: a 24-bit byte address space.
package wsc_pkg;
    // Which stall rule applies to an address
    typedef enum logic [1:0] {
        RGN_OTHER = 2'd0,
        RGN_RAM   = 2'd1,
        RGN_SLOW  = 2'd2
    } region_e;
endpackage

// File: rtl/wsc_addr_decode.sv
// Module: sorts a bus address into the shared-RAM window, the slow-peripheral
// window or neither. Purely combinational.
// Assumes: RAM_LAST < SLOW_BASE, so the two windows never overlap.
module wsc_addr_decode
    import wsc_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] RAM_LAST  = 24'h3F_FFFF,
    parameter logic [23:0] SLOW_BASE = 24'hE0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region
);
    // Window compare: the RAM window starts at zero, the slow window runs to the top
    always_comb begin
        if (addr <= ADDR_W'(RAM_LAST))
            region = RGN_RAM;
        else if (addr >= ADDR_W'(SLOW_BASE))
            region = RGN_SLOW;
        else
            region = RGN_OTHER;
    end
endmodule

// File: rtl/wsc_eclk_gen.sv
// Module: divides the CPU clock by DIV into the slow bus clock. The first
// LOW_CYC counts of each period are low and the rest are high.
// Assumes: 0 < LOW_CYC < DIV.
module wsc_eclk_gen #(
    parameter int DIV     = 10,
    parameter int LOW_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic eclk
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Phase counter: wraps to zero after DIV-1 and is held at zero in reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Clock level from the phase: low part first
    assign eclk = (cnt_q >= CW'(LOW_CYC));

    // The high phase lasts more than one cycle
    assert_eclk_high_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eclk) |=> eclk);
    // A falling edge only happens at the wrap of the period
    assert_eclk_fall_at_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eclk) |-> (cnt_q == '0));
endmodule

// File: rtl/wsc_slow_sync.sv
// Module: the two-step handshake for slow-window accesses. The first strobed
// cycle always stalls and arms the flag. While the flag is armed, the first
// cycle with the slow clock low releases the access and disarms the flag.
// Assumes: slow_acc is high only when the strobe is high.
module wsc_slow_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_acc,
    input  logic eclk,
    output logic stall,
    output logic busy
);
    logic flag_q;
    logic release_now;

    // Release when armed and the slow clock is low
    assign release_now = flag_q && !eclk;
    assign stall       = slow_acc && !release_now;
    assign busy        = flag_q;

    // Sync flag: armed on a stalled slow cycle, cleared otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else
            flag_q <= slow_acc && !release_now;
    end

    // A cycle with no slow access leaves no sync pending
    assert_flag_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !slow_acc |=> !flag_q);
    // An unarmed slow access always stalls
    assert_first_stalls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_acc && !flag_q) |-> stall);
endmodule

// File: rtl/wsc_top.sv
// Module: CPU bus wait-state controller. Decodes the address, applies the
// RAM interleave rule or the slow-clock sync, and registers the ready flag.
// Assumes: bus inputs are synchronous to clk; one decision per clock.
module wsc_top
    import wsc_pkg::*;
#(
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] RAM_LAST  = 24'h3F_FFFF,
    parameter logic [23:0] SLOW_BASE = 24'hE0_0000,
    parameter int          ECLK_DIV  = 10,
    parameter int          ECLK_LOW  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_strobe,
    input  logic              vid_blank,
    input  logic              cpu_slot,
    output logic              eclk_out,
    output logic              bus_ready
);
    region_e region;
    logic    ram_stall;
    logic    slow_acc;
    logic    slow_stall;
    logic    sync_busy;
    logic    hold;
    logic    ready_q;

    wsc_addr_decode #(
        .ADDR_W   (ADDR_W),
        .RAM_LAST (RAM_LAST),
        .SLOW_BASE(SLOW_BASE)
    ) u_dec (
        .addr  (bus_addr),
        .region(region)
    );

    wsc_eclk_gen #(
        .DIV    (ECLK_DIV),
        .LOW_CYC(ECLK_LOW)
    ) u_eclk (
        .clk  (clk),
        .rst_n(rst_n),
        .eclk (eclk_out)
    );

    // Slow-window access qualified by the strobe
    assign slow_acc = bus_strobe && (region == RGN_SLOW);

    wsc_slow_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .slow_acc(slow_acc),
        .eclk    (eclk_out),
        .stall   (slow_stall),
        .busy    (sync_busy)
    );

    // Interleave rule: RAM is free while blanking or in the CPU slot
    assign ram_stall = (region == RGN_RAM) && !vid_blank && !cpu_slot;

    // Combined wait decision, the same for reads and writes
    assign hold = ram_stall || slow_stall;

    // Ready register: one decision per clock, low when no access is strobed
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else
            ready_q <= bus_strobe && !hold;
    end

    assign bus_ready = ready_q;

    assert_no_ready_unstrobed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> !bus_ready);
    assert_ram_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr <= ADDR_W'(RAM_LAST) && !vid_blank && !cpu_slot) |=> !bus_ready);
    assert_ram_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr <= ADDR_W'(RAM_LAST) && (vid_blank || cpu_slot)) |=> bus_ready);
    assert_other_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr > ADDR_W'(RAM_LAST) && bus_addr < ADDR_W'(SLOW_BASE)) |=> bus_ready);
    assert_slow_first_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr >= ADDR_W'(SLOW_BASE) && !sync_busy) |=> !bus_ready);
    assert_slow_release_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_strobe && bus_addr >= ADDR_W'(SLOW_BASE) && sync_busy && !eclk_out) |=> bus_ready);
endmodule

// File: tb/tb_wsc_top.sv
// Bench: sweeps addresses near every window edge, all blank/slot pairs and
// many hold lengths, with a cycle model of the rules computed in the bench.
module tb_wsc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        bus_strobe = 1'b0;
    logic        vid_blank = 1'b0;
    logic        cpu_slot = 1'b0;
    logic        eclk_out;
    logic        bus_ready;

    int n_cmp = 0;
    int n_bad = 0;
    int n_cyc = 0;
    int wd    = 0;
    bit m_flag = 1'b0;
    bit have_exp = 1'b0;
    bit exp_ready = 1'b0;
    string exp_tag = "";

    always #2.5 clk = ~clk;

    wsc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_strobe(bus_strobe),
        .vid_blank (vid_blank),
        .cpu_slot  (cpu_slot),
        .eclk_out  (eclk_out),
        .bus_ready (bus_ready)
    );

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, n_cyc);
        end
    endtask

    // One cycle: check the previous decision, drive, predict, wait a clock
    task automatic step(input logic [23:0] a, input logic s, input logic b, input logic sl);
        bit ec;
        bit w;
        if (have_exp) check(exp_tag, bus_ready, exp_ready);
        check("R8 eclk phase", eclk_out, (n_cyc % 10) >= 6);
        bus_addr = a; bus_strobe = s; vid_blank = b; cpu_slot = sl;
        ec = (n_cyc % 10) >= 6;
        if (!s) begin
            w = 1'b1; m_flag = 1'b0; exp_tag = "R7 no strobe";
        end else if (a <= 24'h3F_FFFF) begin
            w = !b && !sl; m_flag = 1'b0;
            exp_tag = w ? "R2 ram blocked" : "R3 ram free";
        end else if (a >= 24'hE0_0000) begin
            if (!m_flag) begin
                w = 1'b1; m_flag = 1'b1; exp_tag = "R5 first slow cycle";
            end else if (!ec) begin
                w = 1'b0; m_flag = 1'b0; exp_tag = "R6 slow release";
            end else begin
                w = 1'b1; exp_tag = "R6 slow wait high";
            end
        end else begin
            w = 1'b0; m_flag = 1'b0; exp_tag = "R4 other window";
        end
        exp_ready = s && !w;
        have_exp = 1'b1;
        n_cyc = n_cyc + 1;
        @(negedge clk);
    endtask

    logic [23:0] addrs [7];

    initial begin
        addrs[0] = 24'h00_0000; addrs[1] = 24'h3F_FFFF; addrs[2] = 24'h40_0000;
        addrs[3] = 24'h12_3456; addrs[4] = 24'hDF_FFFF; addrs[5] = 24'hE0_0000;
        addrs[6] = 24'hFF_FFFF;
        // Reset state, R1
        repeat (3) @(negedge clk);
        check("R1 reset ready", bus_ready, 1'b0);
        check("R1 reset eclk", eclk_out, 1'b0);
        rst_n = 1'b1;
        // R1: the very first slow access after reset must still stall (R5)
        step(24'hE0_0010, 1'b1, 1'b0, 1'b0);
        check("R1 first cycle eclk", eclk_out, 1'b0);
        // Sweep: address x blank x slot x hold length, strobe drop between
        for (int ai = 0; ai < 7; ai++)
            for (int bs = 0; bs < 4; bs++)
                for (int hl = 1; hl <= 13; hl++) begin
                    for (int k = 0; k < hl; k++)
                        step(addrs[ai], 1'b1, bs[1], bs[0]);
                    step(addrs[ai], 1'b0, bs[1], bs[0]);
                end
        // R7: strobe dropped mid-sync, then a fresh access must re-arm (R5)
        for (int ph = 0; ph < 10; ph++) begin
            step(24'hF0_0000, 1'b1, 1'b0, 1'b0);
            step(24'hF0_0000, 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < ph; k++) step(24'h50_0000, 1'b0, 1'b1, 1'b1);
            step(24'hF0_0000, 1'b1, 1'b0, 1'b0);
            step(24'h20_0000, 1'b1, 1'b0, 1'b1);
            step(24'hF0_0000, 1'b1, 1'b0, 1'b0);
            step(24'hF0_0000, 1'b0, 1'b0, 1'b0);
        end
        step(24'h00_0000, 1'b0, 1'b0, 1'b0);
        check(exp_tag, bus_ready, exp_ready);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule